// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block makes the receive accept/reject decision for Ethernet frames from their destination address. Bytes arrive one per cycle, with a marker on the first byte of each frame. The block keeps the first six bytes as the destination address. While those bytes arrive, it runs a bit-reflected CRC-32 over them. Once it has all six bytes, it checks the address in four ways:
- against the station address;
- against broadcast;
- against the promiscuous control;
- for multicast addresses only, against a 256-bit hash table indexed by the top eight bits of the CRC.

A write-only register port loads the hash table, the station address and the two control bits. The result comes out as a one-cycle decision strobe with an accept flag. Bytes after the sixth in a frame do not affect the decision.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, decision_valid_o and accept_o are 0, the table and station address are all zero, both control bits are clear, and the byte tracker is idle.
- R2: The hash is a CRC-32 that starts at 0xFFFFFFFF and uses the reflected polynomial 0xEDB88320, consuming each address byte least significant bit first, with no final inversion. The table index is bits [31:24] of the CRC after the sixth byte.
- R3: Index bits [7:4] select one of sixteen 16-bit table words and bits [3:0] select the bit in that word. With hash enable set, a multicast address (bit 0 of address byte 0 is 1) is accepted exactly when that bit is 1.
- R4: Table word n (0 to 15) is written by a write to register address 4*n, data bits [15:0].
- R5: The station address is held in three registers. Address 0x40 holds byte 4 in [15:8] and byte 5 in [7:0]. Address 0x44 holds bytes 2 and 3 in the same way, and 0x48 holds bytes 0 and 1. A frame whose address equals the station address is accepted.
- R6: A frame addressed to FF:FF:FF:FF:FF:FF is always accepted.
- R7: The control register at 0x4C holds the promiscuous bit in bit 0 and the hash enable bit in bit 1. While the promiscuous bit is set, every frame is accepted.
- R8: Without the promiscuous bit, a non-broadcast address that does not match the station address is rejected when it is unicast, and also when it is multicast and hash enable is clear.
- R9: decision_valid_o pulses for exactly one cycle, in the cycle after the sixth address byte of a frame is accepted. Further bytes in the frame, and bytes that arrive while idle without a start marker, produce no strobe. accept_o is 0 whenever decision_valid_o is 0.
- R10: A start marker in the middle of a frame restarts the CRC and the address capture from that byte.
- R11: A write to any other address, including one with nonzero low two bits, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte present |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_data_i | input | 8 | Received byte |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 7 | Register byte address |
| cfg_wdata_i | input | 16 | Register write data |
| decision_valid_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted, qualified by decision_valid_o |

## Verification
The embedded assertions check, on every cycle, the following:
- the strobe never lasts two cycles;
- a start marker restarts the byte count;
- the promiscuous and broadcast paths always accept;
- unicast strangers are always rejected;
- a control write lands in the next cycle.

The CRC value, the mapping from hash index to table bit, the station byte ordering and the exclusion of unmapped writes only show up as frame outcomes. The bench's scenarios cover these. It does so by comparing against a behavioural model on every clock, for addresses that are chosen to hit and to miss programmed table bits.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  // reflected CRC, data consumed lsb first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ d[k]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_regs.sv
module mhf_regs #(
  parameter int unsigned AW         = 7,
  parameter int unsigned NWORDS     = 16,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [WORD_W-1:0]          wdata_i,
  output logic [NWORDS*WORD_W-1:0]   table_o,
  output logic [8*ADDR_BYTES-1:0]    station_o,
  output logic                       promisc_o,
  output logic                       hash_en_o
);
  localparam int unsigned STA_REGS = (8 * ADDR_BYTES) / WORD_W;
  localparam int unsigned STA_BASE = NWORDS * 4;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(STA_BASE + 4 * STA_REGS);

  for (genvar n = 0; n < NWORDS; n++) begin : g_tbl
    localparam logic [AW-1:0] WADDR = AW'(n * 4);
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      word_q <= '0;
      else if (we_i && addr_i == WADDR) word_q <= wdata_i;
    end
    assign table_o[n*WORD_W +: WORD_W] = word_q;
  end

  // reg k carries the low-order byte pair k of the address vector (byte 0 in msbs)
  for (genvar k = 0; k < STA_REGS; k++) begin : g_sta
    localparam logic [AW-1:0] SADDR = AW'(STA_BASE + 4 * k);
    logic [WORD_W-1:0] sta_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      sta_q <= '0;
      else if (we_i && addr_i == SADDR) sta_q <= wdata_i;
    end
    assign station_o[k*WORD_W +: WORD_W] = sta_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      promisc_o <= 1'b0;
      hash_en_o <= 1'b0;
    end else if (we_i && addr_i == CTRL_ADDR) begin
      promisc_o <= wdata_i[0];
      hash_en_o <= wdata_i[1];
    end
  end

  assert_ctrl_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CTRL_ADDR) |=> (promisc_o == $past(wdata_i[0]) &&
                                       hash_en_o == $past(wdata_i[1])));

  assert_ctrl_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == CTRL_ADDR) |=> ($stable(promisc_o) && $stable(hash_en_o)));
endmodule

// File: rtl/mhf_addr_crc.sv
module mhf_addr_crc
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned IDX_W      = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sof_i,
  input  logic [7:0]              data_i,
  output logic [IDX_W-1:0]        hash_idx_o,
  output logic [8*ADDR_BYTES-1:0] dst_o,
  output logic                    done_o
);
  localparam int unsigned DST_W = 8 * ADDR_BYTES;
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, base_cnt;
  logic [CRC_W-1:0] crc_q, base_crc;
  logic [DST_W-1:0] dst_q, base_dst;
  logic             take;

  always_comb begin
    base_cnt = sof_i ? '0 : cnt_q;
    base_crc = sof_i ? CRC_INIT : crc_q;
    base_dst = sof_i ? '0 : dst_q;
    take     = valid_i && (sof_i || cnt_q < CNT_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_IDLE;
      crc_q  <= CRC_INIT;
      dst_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= take && base_cnt == CNT_LAST;
      if (take) begin
        cnt_q <= base_cnt + 1'b1;
        crc_q <= crc_byte(base_crc, data_i);
        dst_q <= {base_dst[DST_W-9:0], data_i};
      end
    end
  end

  assign hash_idx_o = crc_q[CRC_W-1 -: IDX_W];
  assign dst_o      = dst_q;

  assert_strobe_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> (cnt_q == 1));

  assert_idle_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_IDLE && !sof_i) |=> ($stable(dst_q) && !done_o));
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide #(
  parameter int unsigned NWORDS     = 16,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned IDX_W      = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NWORDS*WORD_W-1:0]   table_i,
  input  logic [8*ADDR_BYTES-1:0]    station_i,
  input  logic                       promisc_i,
  input  logic                       hash_en_i,
  input  logic [IDX_W-1:0]           hash_idx_i,
  input  logic [8*ADDR_BYTES-1:0]    dst_i,
  input  logic                       done_i,
  output logic                       accept_o
);
  localparam int unsigned DST_W  = 8 * ADDR_BYTES;
  localparam int unsigned BSEL_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sel_word;
  logic is_mcast, is_bcast, is_mine, hash_hit;

  always_comb begin
    sel_word = table_i[int'(hash_idx_i[IDX_W-1:BSEL_W]) * WORD_W +: WORD_W];
    hash_hit = sel_word[hash_idx_i[BSEL_W-1:0]];
    is_mcast = dst_i[DST_W-8];  // group bit: lsb of first byte
    is_bcast = &dst_i;
    is_mine  = dst_i == station_i;
    accept_o = done_i && (promisc_i || is_bcast || is_mine ||
                          (is_mcast && hash_en_i && hash_hit));
  end

  assert_promisc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && promisc_i) |-> accept_o);

  assert_bcast_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && &dst_i) |-> accept_o);

  assert_unicast_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !promisc_i && !dst_i[DST_W-8] && dst_i != station_i) |-> !accept_o);

  assert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> !accept_o);
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int unsigned AW         = 7,
  parameter int unsigned NWORDS     = 16,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic [7:0]        rx_data_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic              decision_valid_o,
  output logic              accept_o
);
  localparam int unsigned IDX_W = $clog2(NWORDS) + $clog2(WORD_W);
  localparam int unsigned DST_W = 8 * ADDR_BYTES;

  logic [NWORDS*WORD_W-1:0] tbl;
  logic [DST_W-1:0]         station, dst;
  logic [IDX_W-1:0]         hash_idx;
  logic                     promisc, hash_en, done;

  mhf_regs #(.AW(AW), .NWORDS(NWORDS), .WORD_W(WORD_W), .ADDR_BYTES(ADDR_BYTES)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .table_o(tbl), .station_o(station), .promisc_o(promisc), .hash_en_o(hash_en)
  );

  mhf_addr_crc #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_track (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .sof_i(rx_sof_i), .data_i(rx_data_i),
    .hash_idx_o(hash_idx), .dst_o(dst), .done_o(done)
  );

  mhf_decide #(.NWORDS(NWORDS), .WORD_W(WORD_W), .ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_dec (
    .clk_i, .rst_ni,
    .table_i(tbl), .station_i(station), .promisc_i(promisc), .hash_en_i(hash_en),
    .hash_idx_i(hash_idx), .dst_i(dst), .done_i(done), .accept_o(accept_o)
  );

  assign decision_valid_o = done;
endmodule

// File: tb/sim_mcast_hash_filter.sv
`timescale 1ns/1ps
module sim_mcast_hash_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic b_valid = 0, b_sof = 0, we = 0;
  logic [7:0] b_data = 0;
  logic [6:0] waddr = 0;
  logic [15:0] wdata = 0;
  logic dv, acc;
  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  mcast_hash_filter u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(b_valid), .rx_sof_i(b_sof), .rx_data_i(b_data),
    .cfg_we_i(we), .cfg_addr_i(waddr), .cfg_wdata_i(wdata),
    .decision_valid_o(dv), .accept_o(acc)
  );

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] x = a[47-8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        if ((c[0] ^ x[0]) == 1'b1) c = (c >> 1) ^ 32'hEDB8_8320;
        else c = c >> 1;
        x = x >> 1;
      end
    end
    return c;
  endfunction

  // behavioural model
  logic [15:0] m_tbl [16];
  logic [15:0] m_sta [3];
  logic m_prom, m_hen, m_valid, m_acc;
  logic [7:0] m_addr [6];
  int m_cnt;

  function automatic logic model_decide();
    logic [47:0] a;
    logic [47:0] s;
    logic [7:0] idx;
    for (int j = 0; j < 6; j++) a[47-8*j -: 8] = m_addr[j];
    s = {m_sta[2], m_sta[1], m_sta[0]};
    idx = ref_crc(a) >> 24;
    return m_prom || (a == 48'hFFFF_FFFF_FFFF) || (a == s) ||
           (a[40] && m_hen && m_tbl[idx / 16][idx % 16]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_tbl[i] = 0;
      for (int i = 0; i < 3; i++) m_sta[i] = 0;
      m_prom = 0; m_hen = 0; m_valid = 0; m_acc = 0; m_cnt = 6;
    end else begin
      if (we) begin
        if (waddr % 4 == 0 && waddr < 64) m_tbl[waddr / 4] = wdata;
        else if (waddr == 64 || waddr == 68 || waddr == 72) m_sta[(waddr - 64) / 4] = wdata;
        else if (waddr == 76) begin m_prom = wdata[0]; m_hen = wdata[1]; end
      end
      m_valid = 0;
      if (b_valid && (b_sof || m_cnt < 6)) begin
        if (b_sof) m_cnt = 0;
        m_addr[m_cnt] = b_data;
        m_cnt++;
        if (m_cnt == 6) m_valid = 1;
      end
      m_acc = m_valid ? model_decide() : 1'b0;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(dv == m_valid, cur_req, "strobe vs model", dv, m_valid);
    chk(acc == m_acc, cur_req, "accept vs model", acc, m_acc);
  end

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; waddr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic send(input logic [47:0] a, input int extra, input logic exp, input string req);
    cur_req = req;
    for (int i = 0; i < 6 + extra; i++) begin
      @(negedge clk);
      if (i == 6) chk(dv == 1 && acc == exp, req, "decision", {dv, acc}, {1'b1, exp});
      b_valid = 1; b_sof = (i == 0); b_data = (i < 6) ? a[47-8*i -: 8] : 8'hA5;
    end
    @(negedge clk);
    b_valid = 0; b_sof = 0;
    if (extra == 0) chk(dv == 1 && acc == exp, req, "decision", {dv, acc}, {1'b1, exp});
    else chk(dv == 0, req, "no strobe on trailing bytes", dv, 0);
    @(negedge clk);
    chk(dv == 0 && acc == 0, req, "strobe one cycle", {dv, acc}, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] ma, mb;
    logic [7:0] ia, ib;
    repeat (3) @(negedge clk);
    chk(dv == 0 && acc == 0, "R1", "reset outputs", {dv, acc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(dv == 0, "R1", "idle after reset", dv, 0);
    send(48'h0A1B2C3D4E5F, 0, 0, "R1");
    send(48'hFFFFFFFFFFFF, 0, 1, "R6");

    // station address 00:11:22:33:44:55
    cur_req = "R5";
    wr(7'h40, 16'h4455); wr(7'h44, 16'h2233); wr(7'h48, 16'h0011);
    send(48'h001122334455, 0, 1, "R5");
    send(48'h001122334456, 0, 0, "R8");
    send(48'h001122334455, 3, 1, "R9");

    // hash hit / miss
    ma = 48'h01005E000001;
    ia = ref_crc(ma) >> 24;
    mb = ma;
    for (int t = 2; t < 200; t++) begin
      mb[7:0] = t[7:0];
      ib = ref_crc(mb) >> 24;
      if (ib != ia) break;
    end
    cur_req = "R4";
    wr(7'h4C, 16'h0002);
    wr(7'(4 * (ia / 16)), 16'(1 << (ia % 16)));
    send(ma, 0, 1, "R2");
    send(mb, 0, 0, "R3");
    wr(7'(4 * (ib / 16)), 16'(1 << (ib % 16)) | ((ib / 16 == ia / 16) ? 16'(1 << (ia % 16)) : 16'h0));
    send(mb, 0, 1, "R3");
    send(ma, 0, 1, "R4");

    // hash disabled
    cur_req = "R8";
    wr(7'h4C, 16'h0000);
    send(ma, 0, 0, "R8");
    send(48'hFFFFFFFFFFFF, 0, 1, "R6");

    // promiscuous
    wr(7'h4C, 16'h0001);
    send(48'h0A1B2C3D4E5F, 0, 1, "R7");
    send(ma, 0, 1, "R7");
    wr(7'h4C, 16'h0002);

    // idle bytes without start marker
    cur_req = "R9";
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); b_valid = 1; b_sof = 0; b_data = 8'hFF;
    end
    @(negedge clk); b_valid = 0;
    @(negedge clk); chk(dv == 0, "R9", "no strobe without start", dv, 0);

    // restart mid-frame
    cur_req = "R10";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); b_valid = 1; b_sof = (i == 0); b_data = 8'hFF;
    end
    send(48'h001122334455, 0, 1, "R10");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); b_valid = 1; b_sof = (i == 0); b_data = 8'h01;
    end
    send(48'h0A1B2C3D4E5F, 0, 0, "R10");

    // unmapped writes
    cur_req = "R11";
    wr(7'h49, 16'hFFFF); wr(7'h4D, 16'h0001); wr(7'h50, 16'hFFFF);
    wr(7'h41, 16'h0000); wr(7'h02, 16'hFFFF);
    send(48'h001122334455, 0, 1, "R11");
    send(48'h0A1B2C3D4E5F, 0, 0, "R11");
    send(ma, 0, 1, "R11");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule